// File: doc/BRIEF.md
# Selectable Dummy Sync Generator

This block produces stand-in horizontal and vertical sync pulses from the reference clock. A display controller uses it when no incoming video is present, for example during burn-in or while an on-screen warning is shown. Both outputs are active high. The vertical timing is counted in generated horizontal lines, and every vertical pulse begins together with a horizontal pulse.

A two-bit select chooses a line multiplier N, so the line lasts `H_UNIT × N` reference clocks. The mapping is not monotonic: code 00 gives N=4, 01 gives N=2, 10 gives N=3 and 11 gives N=5. The horizontal pulse always covers the first eighth of the line. A one-bit select sets the frame length and the vertical pulse width: 0 gives `V_LINES` lines with a pulse of `V_PW` lines, and 1 doubles both values. Select changes take effect only at a frame boundary, so no runt pulses appear. While enable is low, both outputs are held low and the counters are cleared. When enable rises again, a new frame starts from count zero.

Top module: `dsg_top`

## Requirements
- R1: The horizontal period is H_UNIT×N reference clocks (default H_UNIT=64). N is 4 for hsel_i=00, 2 for 01, 3 for 10 and 5 for 11.
- R2: h_sync_o is high for the first H_UNIT×N/8 clocks of each line, starting at line count 0.
- R3: The frame lasts V_LINES lines when vsel_i=0 and 2×V_LINES lines when vsel_i=1 (defaults 512 and 1024).
- R4: v_sync_o is high for the first V_PW lines of the frame when vsel_i=0 and for the first 2×V_PW lines when vsel_i=1 (defaults 8 and 16). Its rising edge coincides with a rising edge of h_sync_o.
- R5: While enabled, a change to hsel_i or vsel_i in mid-frame does not alter the current frame. The new values apply from the next frame start.
- R6: While en_i is low, h_sync_o and v_sync_o are low and both counters are held at zero.
- R7: On the first cycle with en_i high after a low period, both outputs are high and a full line and frame follow, using the selects present at that time.
- R8: After the asynchronous active-low reset, with en_i low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Generation enable |
| hsel_i | input | 2 | Line multiplier select (00→4, 01→2, 10→3, 11→5) |
| vsel_i | input | 1 | Frame length select (0 normal, 1 doubled) |
| h_sync_o | output | 1 | Dummy horizontal sync, active high |
| v_sync_o | output | 1 | Dummy vertical sync, active high |

## Verification
Assertions check the following on every cycle:
- the line and frame counters stay inside their current periods;
- every rising edge of either sync falls at line count zero, with the vertical edge on a horizontal edge;
- the active selects stay frozen between frame boundaries;
- a low enable clears both counters.

Some behaviour is only visible over long stretches of the outputs, so the bench scenarios cover it. This includes the actual period and pulse lengths for each select code, the old line length persisting after a mid-frame select change, and the clean restart after enable toggles. A cycle-level bench model also compares both outputs against the requirements under random selects and enable patterns.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

   typedef logic [1:0] hsel_t;

   // Line multiplier for each horizontal select code (non-monotonic on purpose)
   function automatic int unsigned hmult(input hsel_t code);
      case (code)
         2'b00:   hmult = 4;
         2'b01:   hmult = 2;
         2'b10:   hmult = 3;
         default: hmult = 5;
      endcase
   endfunction

   typedef struct packed {
      hsel_t hsel;
      logic  vsel;
   } mode_t;

endpackage

// File: rtl/dsg_cycle_ctr.sv
// Wrapping counter with synchronous clear; reused for line and frame timing.
module dsg_cycle_ctr #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         adv_i,
   input  logic [W-1:0] last_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);

   logic at_last;
   assign at_last = (cnt_o == last_i);
   assign wrap_o  = adv_i & at_last & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_o <= '0;
      else if (clr_i)      cnt_o <= '0;
      else if (adv_i) begin
         if (at_last)      cnt_o <= '0;
         else              cnt_o <= cnt_o + 1'b1;
      end
   end

   // R6: a clear request leaves the count at zero on the following cycle
   a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));

   // R1/R3: the counter never runs past the terminal value it was given
   a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !clr_i && at_last) |=> (cnt_o == '0));

endmodule

// File: rtl/dsg_mode_reg.sv
// Holds the select values that are in force for the running frame.
module dsg_mode_reg
   import dsg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  mode_t req_i,
   output mode_t act_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      act_o <= '0;
      else if (load_i) act_o <= req_i;
   end

   // R5: outside a frame boundary (or a disabled period) the active mode is frozen
   a_r5_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(act_o));

endmodule

// File: rtl/dsg_top.sv
module dsg_top
   import dsg_pkg::*;
#(
   parameter int unsigned H_UNIT  = 64,
   parameter int unsigned PW_DIV  = 8,
   parameter int unsigned V_LINES = 512,
   parameter int unsigned V_PW    = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic [1:0] hsel_i,
   input  logic       vsel_i,
   output logic       h_sync_o,
   output logic       v_sync_o
);

   localparam int unsigned HMAX = H_UNIT * 5;
   localparam int unsigned HW   = $clog2(HMAX);
   localparam int unsigned LMAX = V_LINES * 2;
   localparam int unsigned LW   = $clog2(LMAX);

   // Elaboration-time parameter checks
   if (H_UNIT % PW_DIV != 0 || H_UNIT < PW_DIV) begin : g_bad_hunit
      $error("dsg_top: H_UNIT must be a nonzero multiple of PW_DIV");
   end
   if (V_PW == 0 || V_PW >= V_LINES) begin : g_bad_vpw
      $error("dsg_top: V_PW must be between 1 and V_LINES-1");
   end
   if (V_LINES < 2) begin : g_bad_vlines
      $error("dsg_top: V_LINES must be at least 2");
   end

   // Per-code line terminal values and pulse widths
   logic [HW-1:0] last_tab [4];
   logic [HW-1:0] hpw_tab  [4];
   for (genvar g = 0; g < 4; g++) begin : g_htab
      localparam int unsigned PER = H_UNIT * hmult(hsel_t'(g));
      assign last_tab[g] = HW'(PER - 1);
      assign hpw_tab[g]  = HW'(PER / PW_DIV);
   end

   mode_t req, act;
   logic  frame_end, mode_load;
   assign req = '{hsel: hsel_i, vsel: vsel_i};

   dsg_mode_reg u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (mode_load),
      .req_i  (req),
      .act_o  (act)
   );

   logic [HW-1:0] h_cnt, h_last;
   logic          h_wrap;
   assign h_last = last_tab[act.hsel];

   dsg_cycle_ctr #(.W(HW)) u_hctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (~en_i),
      .adv_i  (1'b1),
      .last_i (h_last),
      .cnt_o  (h_cnt),
      .wrap_o (h_wrap)
   );

   logic [LW-1:0] v_cnt, v_last, v_pw;
   logic          v_wrap;
   assign v_last = act.vsel ? LW'(LMAX - 1)   : LW'(V_LINES - 1);
   assign v_pw   = act.vsel ? LW'(V_PW * 2)    : LW'(V_PW);

   dsg_cycle_ctr #(.W(LW)) u_vctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (~en_i),
      .adv_i  (h_wrap),
      .last_i (v_last),
      .cnt_o  (v_cnt),
      .wrap_o (v_wrap)
   );

   assign frame_end = h_wrap & v_wrap;
   assign mode_load = ~en_i | frame_end;

   assign h_sync_o = en_i & (h_cnt < hpw_tab[act.hsel]);
   assign v_sync_o = en_i & (v_cnt < v_pw);

   // R1: line count stays within the active line length
   a_r1_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      h_cnt <= h_last);
   // R3: line index stays within the active frame length
   a_r3_v_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      v_cnt <= v_last);
   // R2: a horizontal pulse only begins at line count zero
   a_r2_h_starts_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(h_sync_o) |-> (h_cnt == '0));
   // R4: a vertical pulse only begins together with a horizontal pulse
   a_r4_v_on_h: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(v_sync_o) |-> (h_sync_o && h_cnt == '0 && v_cnt == '0));

endmodule

// File: tb/tb_dsg_top.sv
module tb_dsg_top;

   localparam int unsigned HU  = 16;
   localparam int unsigned VL  = 32;
   localparam int unsigned VPW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0;
   logic [1:0] hsel_i = 2'b00;
   logic       vsel_i = 1'b0;
   logic       h_sync_o, v_sync_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   dsg_top #(.H_UNIT(HU), .PW_DIV(8), .V_LINES(VL), .V_PW(VPW)) dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .hsel_i(hsel_i), .vsel_i(vsel_i),
      .h_sync_o(h_sync_o), .v_sync_o(v_sync_o)
   );

   function automatic int exp_mult(input logic [1:0] s);
      case (s)
         2'b00:   return 4;
         2'b01:   return 2;
         2'b10:   return 3;
         default: return 5;
      endcase
   endfunction
   function automatic int exp_hper(input logic [1:0] s); return HU * exp_mult(s); endfunction
   function automatic int exp_hpw(input logic [1:0] s);  return exp_hper(s) / 8;  endfunction
   function automatic int exp_lines(input logic v);      return v ? 2*VL : VL;    endfunction
   function automatic int exp_vpw(input logic v);        return v ? 2*VPW : VPW;  endfunction

   // Requirement-level model of position in line/frame and active selects
   int         m_h = 0, m_l = 0;
   logic [1:0] m_hs = 2'b00;
   logic       m_vs = 1'b0;

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", req, cycles, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // One clock: advance model at the edge, compare outputs at the falling edge
   task automatic cyc();
      @(posedge clk);
      cycles++;
      if (!rst_n || !en_i) begin
         m_h = 0; m_l = 0; m_hs = hsel_i; m_vs = vsel_i;
      end else if (m_h == exp_hper(m_hs) - 1) begin
         m_h = 0;
         if (m_l == exp_lines(m_vs) - 1) begin
            m_l = 0; m_hs = hsel_i; m_vs = vsel_i;   // R5 frame boundary load
         end else m_l++;
      end else m_h++;
      @(negedge clk);
      check("R1/R2 model h_sync", h_sync_o, en_i && (m_h < exp_hpw(m_hs)));
      check("R3/R4 model v_sync", v_sync_o, en_i && (m_l < exp_vpw(m_vs)));
   endtask

   // R1, R2, R7: line length and pulse width for one select code from a clean start
   task automatic run_h(input logic [1:0] s);
      int hi, per;
      logic prev;
      en_i = 1'b0; hsel_i = s; vsel_i = 1'b0;
      cyc();
      en_i = 1'b1;
      #1;
      check("R7 h_sync high on restart", h_sync_o, 1'b1);
      check("R7 v_sync high on restart", v_sync_o, 1'b1);
      hi = 1; per = 0; prev = h_sync_o;
      for (int k = 1; k <= 400; k++) begin
         cyc();
         if (h_sync_o && !prev) begin per = k; break; end
         if (h_sync_o) hi++;
         prev = h_sync_o;
      end
      check_int("R1 line period", per, exp_hper(s));
      check_int("R2 line pulse width", hi, exp_hpw(s));
   endtask

   // R3, R4: frame length and vertical pulse width in clocks
   task automatic run_v(input logic v);
      int hi, per;
      logic prev;
      en_i = 1'b0; hsel_i = 2'b01; vsel_i = v;
      cyc();
      en_i = 1'b1;
      #1;
      hi = 1; per = 0; prev = v_sync_o;
      for (int k = 1; k <= 20000; k++) begin
         cyc();
         if (v_sync_o && !prev) begin
            per = k;
            check("R4 v edge with h pulse", h_sync_o, 1'b1);
            break;
         end
         if (v_sync_o) hi++;
         prev = v_sync_o;
      end
      check_int("R3 frame period", per, exp_lines(v) * exp_hper(2'b01));
      check_int("R4 frame pulse width", hi, exp_vpw(v) * exp_hper(2'b01));
   endtask

   // R5: mid-frame select change keeps the old line length until frame end
   task automatic run_switch();
      int per, last;
      logic prev;
      en_i = 1'b0; hsel_i = 2'b01; vsel_i = 1'b0;
      cyc();
      en_i = 1'b1;
      repeat (40) cyc();
      hsel_i = 2'b11;
      vsel_i = 1'b1;
      prev = h_sync_o; last = 0; per = 0;
      for (int k = 1; k <= 400; k++) begin
         cyc();
         if (h_sync_o && !prev) begin
            if (last != 0) begin per = k - last; break; end
            last = k;
         end
         prev = h_sync_o;
      end
      check_int("R5 old line length kept mid-frame", per, exp_hper(2'b01));
      prev = v_sync_o;
      for (int k = 0; k < 20000; k++) begin
         cyc();
         if (v_sync_o && !prev) break;
         prev = v_sync_o;
      end
      prev = h_sync_o; per = 0;
      for (int k = 1; k <= 400; k++) begin
         cyc();
         if (h_sync_o && !prev) begin per = k; break; end
         prev = h_sync_o;
      end
      check_int("R5 new line length after frame", per, exp_hper(2'b11));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = 32'd20240607;
      void'($urandom(seed));
      repeat (3) cyc();
      check("R8 h_sync low in reset", h_sync_o, 1'b0);
      check("R8 v_sync low in reset", v_sync_o, 1'b0);
      rst_n = 1'b1;
      cyc();
      check("R8 h_sync low after reset", h_sync_o, 1'b0);
      check("R8 v_sync low after reset", v_sync_o, 1'b0);

      for (int s = 0; s < 4; s++) run_h(2'(s));
      run_v(1'b0);
      run_v(1'b1);
      run_switch();

      // R6: dropping enable mid-pulse forces outputs low at once and stays low
      en_i = 1'b0; hsel_i = 2'b10; cyc();
      en_i = 1'b1; repeat (3) cyc();
      en_i = 1'b0;
      #1;
      check("R6 h_sync low when disabled", h_sync_o, 1'b0);
      check("R6 v_sync low when disabled", v_sync_o, 1'b0);
      repeat (50) cyc();
      check("R6 h_sync held low", h_sync_o, 1'b0);
      en_i = 1'b1;
      #1;
      check("R7 h_sync restarts high", h_sync_o, 1'b1);

      // Random segments checked cycle by cycle against the model
      for (int seg = 0; seg < 30; seg++) begin
         int len;
         len = int'($urandom_range(20, 2500));
         hsel_i = 2'($urandom_range(0, 3));
         vsel_i = 1'($urandom_range(0, 1));
         en_i   = ($urandom_range(0, 4) != 0);
         repeat (len) cyc();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule